// File: doc/BRIEF.md
# Trigger Selector with Busy Lockout

This block forms the acquisition trigger for a multi-detector readout system. Five source lines feed it: bit 0 is the primary-detector singles (already downscaled), bit 1 the secondary-detector singles (already downscaled), bit 2 the coincidence, and bits 3 and 4 two external lines. Each line has its own enable bit. The OR of the enabled lines is the raw trigger. The raw trigger passes as the live trigger only while the busy latch is clear.

A raw trigger seen while the block is idle opens an event, and busy rises a fixed `SET_DLY` cycles later (2 cycles, 50 ns at 40 MHz). The five source lines are delayed by the same `SET_DLY` cycles and OR-ed into a pattern word during a programmable coincidence window. The event also does four things:
- it latches the incoming time stamp;
- it raises an event request that stays high until acknowledged;
- it starts three converter gate generators (ADC, QDC, TDC);
- it can only be closed by a busy-clear from the readout computer, and that clear is accepted only after the window has ended.

Every source line has its own rising-edge scaler, because one physical event can produce several raw pulses. A read port returns the pattern word first, then the time stamp, then the scalers.

The controller has four states:
- `ST_IDLE`: not busy.
- `ST_ARM`: the delay before busy rises.
- `ST_WIN`: busy, with the coincidence window open.
- `ST_HOLD`: busy, waiting for the clear.

It has four transitions:
- `IDLE→ARM` on a raw trigger.
- `ARM→WIN` when the delay count expires.
- `WIN→HOLD` after the window length.
- `HOLD→IDLE` on busy-clear.

Top module: `trig_select`

## Requirements
- R1: `raw_trig` equals the OR over i of (`src_in[i]` AND `src_en[i]`), combinationally in the same cycle.
- R2: `live_trig` equals `raw_trig` while `busy` is low, and is low whenever `busy` is high.
- R3: A raw trigger in cycle c, seen while idle, makes `busy` high from cycle c+`SET_DLY` (c+2 by default). `busy` then stays high until it is cleared.
- R4: `busy_clr` is acted on only in `ST_HOLD`, that is, after the window has closed. There it drops `busy` in the next cycle. A clear during the delay or the window is ignored.
- R5: The `pattern` bit i becomes 1 if `src_in[i]` is high in any of the cycles c..c+`coinc_len`-1, whether or not that line is enabled. Bit 0 is primary, bit 1 secondary, bit 2 coincidence, bit 3 external 1 and bit 4 external 2. The word holds until busy-clear, which zeroes it.
- R6: `evt_req` rises in cycle c+1 of an accepted event and holds until an `evt_ack` cycle. A new event in the same cycle as an acknowledge wins.
- R7: The ADC, QDC and TDC gates are each high for exactly their programmed width in cycles. They start in cycle c+1 of an accepted event. A width of 0 gives no gate.
- R8: Each source line has a scaler that counts rising edges of `src_in[i]` regardless of enable or busy. It wraps at 2^`CNT_W`, and `scaler_clr` zeroes it.
- R9: A read with `rd_en` returns `rd_data` in the next cycle. Address 0 is the pattern. Addresses 1, 2 and 3 are time stamp bits [15:0], [31:16] and [47:32], taken at event acceptance. Addresses 8+2i and 9+2i are the low and high halves of scaler i. Any other address returns 0.
- R10: `rd_done` is set by a read of address 3 and cleared when busy is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 5 | Trigger source lines |
| src_en | input | 5 | Per-line enables |
| coinc_len | input | GATE_W | Coincidence window length in cycles (0 acts as 1) |
| gate_w_adc | input | GATE_W | ADC gate width |
| gate_w_qdc | input | GATE_W | QDC gate width |
| gate_w_tdc | input | GATE_W | TDC gate width |
| ts_in | input | 48 | Running time stamp |
| busy_clr | input | 1 | Readout done; release busy |
| evt_ack | input | 1 | Acknowledge event request |
| scaler_clr | input | 1 | Zero all scalers |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| raw_trig | output | 1 | OR of enabled sources |
| live_trig | output | 1 | Raw trigger not blocked by busy |
| busy | output | 1 | Busy latch |
| evt_req | output | 1 | Latched event request |
| adc_gate | output | 1 | ADC gate |
| qdc_gate | output | 1 | QDC gate |
| tdc_gate | output | 1 | TDC gate |
| pattern | output | 5 | Captured source pattern |
| rd_data | output | 16 | Read data |
| rd_done | output | 1 | Last time stamp word read |

## Verification
The hardest situations to reach are those that depend on where the controller sits within an event. The cases are:
- a busy-clear arriving while the window is still open;
- a second source arriving after busy has risen but still inside the window;
- a source arriving exactly one cycle past the window's end.

The bench gets there by counting cycles from a single-cycle trigger. It places the clear, the late source and the out-of-window source in named cycles relative to that trigger. It also sweeps all 31 nonzero patterns behind a trigger on line 0 alone, so disabled lines show up in the pattern. Scaler wrap is reached by building the bench with a 4-bit scaler width.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
    localparam int NSRC      = 5;
    localparam int TS_W      = 48;
    localparam int WORD_W    = 16;
    localparam int SCAL_BASE = 8;
    localparam int NGATE     = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_WIN,
        ST_HOLD
    } evt_state_e;
endpackage

// File: rtl/trig_scaler.sv
module trig_scaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sig,
    output logic [CNT_W-1:0] count
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
            count <= '0;
        end else begin
            sig_q <= sig;
            if (clr)
                count <= '0;
            else if (sig && !sig_q)
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/trig_gate_gen.sv
module trig_gate_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] width,
    output logic         gate
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (start && left_q == '0)
            left_q <= width;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign gate = (left_q != '0);
endmodule

// File: rtl/trig_readout.sv
module trig_readout
    import trig_sel_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int AW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [AW-1:0]         rd_addr,
    input  logic [NSRC-1:0]       pattern,
    input  logic [TS_W-1:0]       stamp,
    input  logic [NSRC*CNT_W-1:0] scal,
    output logic [WORD_W-1:0]     rd_data
);
    logic [31:0]       scal_wide [NSRC];
    logic [WORD_W-1:0] word_d;

    for (genvar g = 0; g < NSRC; g++) begin : g_ext
        assign scal_wide[g] = 32'(scal[g*CNT_W +: CNT_W]);
    end

    always_comb begin
        word_d = '0;
        if (rd_addr == AW'(0)) word_d = WORD_W'(pattern);
        if (rd_addr == AW'(1)) word_d = stamp[15:0];
        if (rd_addr == AW'(2)) word_d = stamp[31:16];
        if (rd_addr == AW'(3)) word_d = stamp[47:32];
        for (int i = 0; i < NSRC; i++) begin
            if (int'(rd_addr) == SCAL_BASE + 2*i)     word_d = scal_wide[i][15:0];
            if (int'(rd_addr) == SCAL_BASE + 2*i + 1) word_d = scal_wide[i][31:16];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= word_d;
    end
endmodule

// File: rtl/trig_select.sv
module trig_select
    import trig_sel_pkg::*;
#(
    parameter int SET_DLY = 2,
    parameter int CNT_W   = 32,
    parameter int GATE_W  = 8,
    parameter int AW      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        src_in,
    input  logic [4:0]        src_en,
    input  logic [GATE_W-1:0] coinc_len,
    input  logic [GATE_W-1:0] gate_w_adc,
    input  logic [GATE_W-1:0] gate_w_qdc,
    input  logic [GATE_W-1:0] gate_w_tdc,
    input  logic [47:0]       ts_in,
    input  logic              busy_clr,
    input  logic              evt_ack,
    input  logic              scaler_clr,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              raw_trig,
    output logic              live_trig,
    output logic              busy,
    output logic              evt_req,
    output logic              adc_gate,
    output logic              qdc_gate,
    output logic              tdc_gate,
    output logic [4:0]        pattern,
    output logic [15:0]       rd_data,
    output logic              rd_done
);
    localparam logic [GATE_W-1:0] ARM_LAST = GATE_W'(SET_DLY - 2);

    evt_state_e        state_q, state_d;
    logic [GATE_W-1:0] cnt_q;
    logic [GATE_W-1:0] win_last;
    logic              accept;
    logic              release_evt;
    logic [NSRC-1:0]   dly_q [SET_DLY];
    logic [NSRC-1:0]   src_dly;
    logic [TS_W-1:0]   stamp_q;
    logic [NSRC*CNT_W-1:0] scal_flat;
    logic [GATE_W-1:0] gate_w [NGATE];
    logic              gate_o [NGATE];

    // trigger formation
    assign raw_trig    = |(src_in & src_en);
    assign busy        = (state_q == ST_WIN) || (state_q == ST_HOLD);
    assign live_trig   = raw_trig && !busy;
    assign accept      = (state_q == ST_IDLE) && raw_trig;
    assign release_evt = (state_q == ST_HOLD) && busy_clr;
    assign win_last    = (coinc_len == '0) ? '0 : coinc_len - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (raw_trig)           state_d = (SET_DLY == 2) ? ST_ARM : ST_ARM;
            ST_ARM:  if (cnt_q == ARM_LAST)  state_d = ST_WIN;
            ST_WIN:  if (cnt_q >= win_last)  state_d = ST_HOLD;
            ST_HOLD: if (busy_clr)           state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // source delay line feeding the coincidence register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SET_DLY; k++) dly_q[k] <= '0;
        end else begin
            dly_q[0] <= src_in;
            for (int k = 1; k < SET_DLY; k++) dly_q[k] <= dly_q[k-1];
        end
    end
    assign src_dly = dly_q[SET_DLY-1];

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern <= '0;
            evt_req <= 1'b0;
            stamp_q <= '0;
            rd_done <= 1'b0;
        end else begin
            if (release_evt)
                pattern <= '0;
            else if (state_q == ST_WIN)
                pattern <= pattern | src_dly;

            if (accept)
                evt_req <= 1'b1;
            else if (evt_ack)
                evt_req <= 1'b0;

            if (accept)
                stamp_q <= ts_in;

            if (release_evt)
                rd_done <= 1'b0;
            else if (rd_en && rd_addr == AW'(3))
                rd_done <= 1'b1;
        end
    end

    // converter gates
    assign gate_w[0] = gate_w_adc;
    assign gate_w[1] = gate_w_qdc;
    assign gate_w[2] = gate_w_tdc;
    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        trig_gate_gen #(.W(GATE_W)) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .start (accept),
            .width (gate_w[g]),
            .gate  (gate_o[g])
        );
    end
    assign adc_gate = gate_o[0];
    assign qdc_gate = gate_o[1];
    assign tdc_gate = gate_o[2];

    // per-line scalers
    for (genvar g = 0; g < NSRC; g++) begin : g_scal
        trig_scaler #(.CNT_W(CNT_W)) u_scal (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (scaler_clr),
            .sig   (src_in[g]),
            .count (scal_flat[g*CNT_W +: CNT_W])
        );
    end

    trig_readout #(.CNT_W(CNT_W), .AW(AW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .pattern (pattern),
        .stamp   (stamp_q),
        .scal    (scal_flat),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/trig_select_chk.sv
module trig_select_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          busy_clr,
    input logic          evt_req,
    input logic          evt_ack,
    input logic          live_trig,
    input logic          adc_gate,
    input logic          qdc_gate,
    input logic [4:0]    pattern,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          rd_done
);
    // R3
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_clr));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_req) |-> $past(evt_ack));

    // R7
    adc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_gate) |-> $past(live_trig));

    // R7
    qdc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qdc_gate) |-> $past(live_trig));

    // R5
    pattern_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pattern) & ~pattern) != 5'b0) |-> $past(busy_clr));

    // R10
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> $past(rd_en && rd_addr == AW'(3)));
endmodule

bind trig_select trig_select_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .busy_clr  (busy_clr),
    .evt_req   (evt_req),
    .evt_ack   (evt_ack),
    .live_trig (live_trig),
    .adc_gate  (adc_gate),
    .qdc_gate  (qdc_gate),
    .pattern   (pattern),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_done   (rd_done)
);

// File: tb/trig_select_tb.sv
module trig_select_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  src_in, src_en;
    logic [7:0]  coinc_len, gate_w_adc, gate_w_qdc, gate_w_tdc;
    logic [47:0] ts_in;
    logic        busy_clr, evt_ack, scaler_clr, rd_en;
    logic [4:0]  rd_addr;
    logic        raw_trig, live_trig, busy, evt_req, adc_gate, qdc_gate, tdc_gate, rd_done;
    logic [4:0]  pattern;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    trig_select #(.CNT_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
        .coinc_len(coinc_len), .gate_w_adc(gate_w_adc), .gate_w_qdc(gate_w_qdc),
        .gate_w_tdc(gate_w_tdc), .ts_in(ts_in), .busy_clr(busy_clr),
        .evt_ack(evt_ack), .scaler_clr(scaler_clr), .rd_en(rd_en), .rd_addr(rd_addr),
        .raw_trig(raw_trig), .live_trig(live_trig), .busy(busy), .evt_req(evt_req),
        .adc_gate(adc_gate), .qdc_gate(qdc_gate), .tdc_gate(tdc_gate),
        .pattern(pattern), .rd_data(rd_data), .rd_done(rd_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // inputs change 2 ns after a rising edge; probe 1 ns later
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic probe();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src_in = '0; src_en = '0; coinc_len = 8'd4;
        gate_w_adc = 8'd3; gate_w_qdc = 8'd1; gate_w_tdc = 8'd0;
        ts_in = '0; busy_clr = 0; evt_ack = 0; scaler_clr = 0; rd_en = 0; rd_addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        tick(); rd_en = 1'b1; rd_addr = a;
        tick(); rd_en = 1'b0;
        probe(); d = rd_data;
    endtask

    task automatic release_busy();
        tick(); busy_clr = 1'b1;
        tick(); busy_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        do_reset();
        probe();
        chk("R3 reset busy", busy, 0);
        chk("R6 reset evt_req", evt_req, 0);
        chk("R5 reset pattern", pattern, 0);
        chk("R7 reset gates", {adc_gate, qdc_gate, tdc_gate}, 0);
        chk("R10 reset rd_done", rd_done, 0);

        // R1 / R2: full sweep of enables and sources
        for (int e = 0; e < 32; e++) begin
            for (int s = 0; s < 32; s++) begin
                tick(); src_en = 5'(e); src_in = 5'(s);
                probe();
                chk("R1 raw OR", raw_trig, |(5'(e) & 5'(s)));
                chk("R2 live gating", live_trig, busy ? 1'b0 : raw_trig);
            end
        end

        // single event walk-through
        do_reset();
        src_en = 5'b11111; ts_in = 48'h1234_5678_9ABC;
        tick(); src_in = 5'b00001;                       // cycle c0
        probe();
        chk("R2 live at c0", live_trig, 1);
        chk("R3 busy at c0", busy, 0);
        tick(); src_in = '0; ts_in = 48'hFFFF_FFFF_FFFF; // c1
        probe();
        chk("R3 busy at c1", busy, 0);
        chk("R6 evt_req at c1", evt_req, 1);
        chk("R7 gates at c1", {adc_gate, qdc_gate, tdc_gate}, 3'b110);
        tick(); src_in = 5'b10000; busy_clr = 1'b1;      // c2
        probe();
        chk("R3 busy at c2", busy, 1);
        chk("R2 live blocked", live_trig, 0);
        chk("R7 gates at c2", {adc_gate, qdc_gate, tdc_gate}, 3'b100);
        tick(); src_in = '0; busy_clr = 1'b0;            // c3
        probe();
        chk("R4 clear in window ignored", busy, 1);
        chk("R7 adc at c3", adc_gate, 1);
        tick(); probe();                                 // c4
        chk("R7 adc ended", adc_gate, 0);
        repeat (4) tick();
        probe();
        chk("R5 pattern late source", pattern, 5'b10001);
        chk("R3 busy holds", busy, 1);
        tick(); evt_ack = 1'b1;
        tick(); evt_ack = 1'b0;
        probe();
        chk("R6 evt_req acked", evt_req, 0);
        rd(5'd0, d); chk("R9 addr0 pattern", d, 16'h0011);
        rd(5'd1, d); chk("R9 stamp low", d, 16'h9ABC);
        rd(5'd2, d); chk("R9 stamp mid", d, 16'h5678);
        chk("R10 not yet done", rd_done, 0);
        rd(5'd3, d); chk("R9 stamp high", d, 16'h1234);
        chk("R10 done set", rd_done, 1);
        rd(5'd5, d); chk("R9 unmapped", d, 0);
        release_busy();
        probe();
        chk("R4 busy released", busy, 0);
        chk("R5 pattern cleared", pattern, 0);
        chk("R10 done cleared", rd_done, 0);

        // R5 sweep: trigger on line 0 only, others disabled but recorded
        src_en = 5'b00001;
        for (int p = 1; p < 32; p++) begin
            tick(); src_in = 5'(p) | 5'b00001;
            tick(); src_in = '0;
            probe(); chk("R3 busy c1 sweep", busy, 0);
            tick(); probe(); chk("R3 busy c2 sweep", busy, 1);
            repeat (6) tick();
            probe();
            chk("R5 pattern sweep", pattern, 5'(p) | 5'b00001);
            release_busy();
            tick();
        end

        // R5 window boundary with coinc_len = 4
        tick(); src_in = 5'b00001;
        tick(); src_in = '0;
        tick();
        tick(); src_in = 5'b01000;   // c3: last window cycle
        tick(); src_in = 5'b10000;   // c4: outside
        tick(); src_in = '0;
        repeat (4) tick();
        probe();
        chk("R5 window edge", pattern, 5'b01001);
        release_busy();

        // R8 scalers, 4-bit width in this bench
        do_reset();
        src_en = '0;
        tick(); scaler_clr = 1'b1;
        tick(); scaler_clr = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick(); src_in = 5'b00100;
            tick(); src_in = '0;
        end
        for (int i = 0; i < 17; i++) begin
            tick(); src_in = 5'b01000;
            tick(); src_in = '0;
        end
        tick(); src_in = 5'b00001;
        repeat (3) tick();
        src_in = '0;
        tick();
        rd(5'd12, d); chk("R8 line2 count", d, 5);
        rd(5'd14, d); chk("R8 line3 wrap", d, 17 % 16);
        rd(5'd8, d);  chk("R8 line0 held high", d, 1);
        rd(5'd9, d);  chk("R8 high half", d, 0);
        rd(5'd10, d); chk("R8 idle line", d, 0);
        tick(); scaler_clr = 1'b1;
        tick(); scaler_clr = 1'b0;
        rd(5'd12, d); chk("R8 cleared", d, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule